// File: doc/BRIEF.md
# Dynamic Voltage-Frequency Performance Sequencer

This block turns a requested processor performance level into an ordered pair of moves on the supply voltage and the processor clock. Software writes a level index (0 is the slowest point, the top index is 100% of full performance) over an APB slave port. A programmable table gives, for each level index, the voltage code sent to the external supply controller and the clock-step code sent to the clock generator. Larger clock-step codes mean faster clocks.

The sequencer never lets the clock run ahead of a settled supply. When it moves upward, it raises the voltage first, waits for the supply's ready signal to rise, and only then speeds the clock up. When it moves downward, it slows the clock first and lowers the voltage on the following cycle. A programmable ceiling clamps requests. A request that arrives while a move is under way is held and served once that move ends. A status register shows the current level, the clamped target, a busy flag and the supply's ready line.

Top module: `dvfs_perf_ctrl`

## Requirements
- R1: After reset the current and target levels equal the top index (7 by default), the ceiling is the top index, busy is 0, and `vcode_o`, `clkstep_o` and `perf_lvl_o` carry the reset contents of the top table entry.
- R2: Register offsets are: 0x00 request (bits [2:0], raw value read back), 0x04 ceiling (bits [2:0]), 0x08 status (read only), 0x40 + 4*i table entry i with the voltage code in bits [7:0] and the clock-step code in bits [10:8]. Writes take effect on the APB access cycle, and a table entry reads back what was written.
- R3: The target is the request clamped to the ceiling, min(request, ceiling). Lowering or raising the ceiling re-clamps the target at once.
- R4: Upward move: the new voltage code is driven first. The clock-step code and the current level change only on the cycle after `vrdy_i` is sampled rising (low, then high).
- R5: Downward move: the lower clock-step code is driven first. The lower voltage code follows one cycle later, and the current level updates after `vrdy_i` is then sampled rising.
- R6: A target change during a move does not disturb that move. The newest target is served after it completes.
- R7: The status register holds the current level in bits [7:0], the target in bits [15:8], busy in bit 16 and `vrdy_i` in bit 17. Busy is 1 from the cycle a move starts until the cycle after it completes.
- R8: The reset contents of table entry i are voltage code 64 + 16*i and clock-step code i. Whatever the table holds is what a move drives out.
- R9: A target equal to the current level starts no move. Busy stays 0 and the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB and sequencer clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| vrdy_i | input | 1 | Supply settled indication |
| vcode_o | output | 8 | Voltage code to the supply controller |
| clkstep_o | output | 3 | Clock-step code to the clock generator |
| perf_lvl_o | output | 3 | Current performance level index |

## Verification
The bench builds the block with its default parameters: 8 levels, 8-bit voltage codes and 3-bit clock-step codes. With these values every level, the ceiling clamp at both ends and a rewritten table entry can all be reached within a few hundred cycles. A supply model in the bench drops the ready line whenever the voltage code changes and raises it a fixed number of cycles later. A monitor tracks the order of moves and flags any clock speed-up before the supply has settled, and any voltage drop that is not preceded by a clock slow-down. Moves in both directions are exercised, including a request that lands mid-move and a move whose clock slows while the voltage rises.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  parameter int unsigned NLVL_DEF = 8;
  parameter int unsigned VC_W_DEF = 8;
  parameter int unsigned CK_W_DEF = 3;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_UP_WAIT = 2'd1,
    SQ_DN_VOLT = 2'd2,
    SQ_DN_WAIT = 2'd3
  } seq_st_e;

  // control register word offsets (byte address >> 2) inside region 0
  localparam int unsigned OFS_REQ  = 0;
  localparam int unsigned OFS_CEIL = 1;
  localparam int unsigned OFS_STAT = 2;

  // reset voltage code of table entry idx
  function automatic int unsigned dflt_vcode(input int unsigned idx);
    return 64 + 16 * idx;
  endfunction

  // reset clock-step code of table entry idx
  function automatic int unsigned dflt_clk(input int unsigned idx);
    return idx;
  endfunction
endpackage

// File: rtl/dvfs_regs.sv
module dvfs_regs
  import dvfs_pkg::*;
#(
  parameter int unsigned NLVL = NLVL_DEF,
  parameter int unsigned VW   = VC_W_DEF,
  parameter int unsigned CW   = CK_W_DEF,
  parameter int unsigned AW   = 8,
  localparam int unsigned LW  = $clog2(NLVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [31:0]      pwdata,
  output logic [31:0]      prdata,
  input  logic [LW-1:0]    cur_lvl,
  input  logic             busy,
  input  logic             vrdy,
  output logic [NLVL*VW-1:0] tbl_v,
  output logic [NLVL*CW-1:0] tbl_c,
  output logic [LW-1:0]    tgt_lvl
);
  logic [LW-1:0] req_q, ceil_q;
  logic          wr_acc, in_ctrl, in_tbl;
  logic [LW-1:0] tbl_idx;
  logic [AW-3:0] word_ofs;

  assign wr_acc   = psel & penable & pwrite;
  assign in_ctrl  = (paddr[AW-1:AW-2] == 2'b00);
  assign in_tbl   = (paddr[AW-1:AW-2] == 2'b01);
  assign tbl_idx  = paddr[2 +: LW];
  assign word_ofs = paddr[AW-1:2];

  // R3: clamp request to ceiling
  assign tgt_lvl = (req_q > ceil_q) ? ceil_q : req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= LW'(NLVL - 1);
      ceil_q <= LW'(NLVL - 1);
    end else if (wr_acc && in_ctrl) begin
      if (word_ofs == (AW-2)'(OFS_REQ))  req_q  <= pwdata[LW-1:0];
      if (word_ofs == (AW-2)'(OFS_CEIL)) ceil_q <= pwdata[LW-1:0];
    end
  end

  for (genvar gi = 0; gi < NLVL; gi++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tbl_v[gi*VW +: VW] <= VW'(dflt_vcode(gi));
        tbl_c[gi*CW +: CW] <= CW'(dflt_clk(gi));
      end else if (wr_acc && in_tbl && tbl_idx == LW'(gi)) begin
        tbl_v[gi*VW +: VW] <= pwdata[VW-1:0];
        tbl_c[gi*CW +: CW] <= pwdata[8 +: CW];
      end
    end
  end

  always_comb begin
    prdata = '0;
    if (in_ctrl) begin
      if (word_ofs == (AW-2)'(OFS_REQ))  prdata[LW-1:0] = req_q;
      if (word_ofs == (AW-2)'(OFS_CEIL)) prdata[LW-1:0] = ceil_q;
      if (word_ofs == (AW-2)'(OFS_STAT)) begin
        prdata[LW-1:0]   = cur_lvl;
        prdata[8 +: LW]  = tgt_lvl;
        prdata[16]       = busy;
        prdata[17]       = vrdy;
      end
    end else if (in_tbl) begin
      prdata[VW-1:0] = tbl_v[tbl_idx*VW +: VW];
      prdata[8 +: CW] = tbl_c[tbl_idx*CW +: CW];
    end
  end
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
  import dvfs_pkg::*;
#(
  parameter int unsigned NLVL = NLVL_DEF,
  parameter int unsigned VW   = VC_W_DEF,
  parameter int unsigned CW   = CK_W_DEF,
  localparam int unsigned LW  = $clog2(NLVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LW-1:0]      tgt_lvl,
  input  logic [NLVL*VW-1:0] tbl_v,
  input  logic [NLVL*CW-1:0] tbl_c,
  input  logic               vrdy,
  output logic [VW-1:0]      vcode,
  output logic [CW-1:0]      clkstep,
  output logic [LW-1:0]      cur_lvl,
  output logic               busy
);
  seq_st_e       st;
  logic [LW-1:0] sv_lvl;
  logic          vrdy_q;

  // named internal events
  logic vrdy_rise, up_start, dn_start, move_done;
  assign vrdy_rise = vrdy & ~vrdy_q;
  assign up_start  = (st == SQ_IDLE) && (tgt_lvl > cur_lvl);
  assign dn_start  = (st == SQ_IDLE) && (tgt_lvl < cur_lvl);
  assign move_done = (st == SQ_UP_WAIT || st == SQ_DN_WAIT) && vrdy_rise;
  assign busy      = (st != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      sv_lvl  <= LW'(NLVL - 1);
      cur_lvl <= LW'(NLVL - 1);
      vcode   <= VW'(dflt_vcode(NLVL - 1));
      clkstep <= CW'(dflt_clk(NLVL - 1));
      vrdy_q  <= 1'b1;
    end else begin
      vrdy_q <= vrdy;
      case (st)
        SQ_IDLE: begin
          sv_lvl <= tgt_lvl;
          if (up_start) begin
            vcode <= tbl_v[tgt_lvl*VW +: VW];   // R4: voltage first
            st    <= SQ_UP_WAIT;
          end else if (dn_start) begin
            clkstep <= tbl_c[tgt_lvl*CW +: CW]; // R5: clock first
            st      <= SQ_DN_VOLT;
          end
        end
        SQ_UP_WAIT: if (vrdy_rise) begin
          clkstep <= tbl_c[sv_lvl*CW +: CW];
          cur_lvl <= sv_lvl;
          st      <= SQ_IDLE;
        end
        SQ_DN_VOLT: begin
          vcode <= tbl_v[sv_lvl*VW +: VW];
          st    <= SQ_DN_WAIT;
        end
        SQ_DN_WAIT: if (vrdy_rise) begin
          cur_lvl <= sv_lvl;
          st      <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // R4
  up_clk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_UP_WAIT && !vrdy_rise) |=> $stable(clkstep));
  // R5
  dn_volt_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_start |=> (st == SQ_DN_VOLT && $stable(vcode)));
  // R6
  cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !move_done) |=> ($stable(cur_lvl) && $stable(sv_lvl)));
  // R9
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tgt_lvl != cur_lvl) |=> busy);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tgt_lvl == cur_lvl) |=> ($stable(vcode) && $stable(clkstep)));
endmodule

// File: rtl/dvfs_perf_ctrl.sv
module dvfs_perf_ctrl
  import dvfs_pkg::*;
#(
  parameter int unsigned NLVL = NLVL_DEF,
  parameter int unsigned VW   = VC_W_DEF,
  parameter int unsigned CW   = CK_W_DEF,
  parameter int unsigned AW   = 8,
  localparam int unsigned LW  = $clog2(NLVL)
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          pready,
  input  logic          vrdy_i,
  output logic [VW-1:0] vcode_o,
  output logic [CW-1:0] clkstep_o,
  output logic [LW-1:0] perf_lvl_o
);
  logic [NLVL*VW-1:0] tbl_v;
  logic [NLVL*CW-1:0] tbl_c;
  logic [LW-1:0]      tgt_lvl, cur_lvl;
  logic               busy;

  assign pready     = 1'b1;
  assign perf_lvl_o = cur_lvl;

  dvfs_regs #(.NLVL(NLVL), .VW(VW), .CW(CW), .AW(AW)) u_regs (
    .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .cur_lvl(cur_lvl), .busy(busy), .vrdy(vrdy_i),
    .tbl_v(tbl_v), .tbl_c(tbl_c), .tgt_lvl(tgt_lvl)
  );

  dvfs_seq #(.NLVL(NLVL), .VW(VW), .CW(CW)) u_seq (
    .clk(pclk), .rst_n(presetn), .tgt_lvl(tgt_lvl), .tbl_v(tbl_v),
    .tbl_c(tbl_c), .vrdy(vrdy_i), .vcode(vcode_o), .clkstep(clkstep_o),
    .cur_lvl(cur_lvl), .busy(busy)
  );
endmodule

// File: tb/dvfs_perf_ctrl_bench.sv
module dvfs_perf_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 4;
  localparam int VEC_N      = 6;
  localparam logic [2:0] V_REQ [VEC_N] = '{3'd3, 3'd0, 3'd5, 3'd7, 3'd1, 3'd6};
  localparam logic [7:0] V_VC  [VEC_N] = '{8'h70, 8'h40, 8'h90, 8'hB0, 8'h50, 8'hA0};
  localparam logic [2:0] V_CK  [VEC_N] = '{3'd3, 3'd0, 3'd5, 3'd7, 3'd1, 3'd6};

  logic pclk = 0, presetn = 0, psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata, rd;
  logic pready, vrdy_i = 1;
  logic [7:0] vcode_o;
  logic [2:0] clkstep_o, perf_lvl_o;
  int n_chk = 0, n_fail = 0, mon_err = 0, cnt = 0;
  logic [7:0] sup_last = 8'hB0;

  always #(CLK_PERIOD/2) pclk = ~pclk;

  dvfs_perf_ctrl u_dvfs_perf_ctrl (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .vrdy_i(vrdy_i), .vcode_o(vcode_o),
    .clkstep_o(clkstep_o), .perf_lvl_o(perf_lvl_o)
  );

  // supply model: ready drops on a code change, rises SETTLE cycles later
  always @(negedge pclk) begin
    if (presetn) begin
      if (vcode_o != sup_last) begin
        sup_last = vcode_o; vrdy_i = 0; cnt = SETTLE;
      end else if (cnt > 0) begin
        cnt--; if (cnt == 0) vrdy_i = 1;
      end
    end
  end

  // ordering monitor (R4, R5)
  logic [7:0] pv = 8'hB0;
  logic [2:0] pc = 3'd7;
  bit settled = 1, saw_low = 0, clk_dropped = 0;
  always @(posedge pclk) begin
    #1;
    if (presetn) begin
      if (vcode_o != pv) begin
        if (vcode_o < pv) begin
          n_chk++;
          if (!clk_dropped) begin
            n_fail++; mon_err++;
            $display("FAIL R5 voltage lowered before clock: act vcode=%0h exp clock drop first", vcode_o);
          end
        end
        clk_dropped = 0; settled = 0; saw_low = 0;
      end
      if (!vrdy_i) saw_low = 1; else if (saw_low) settled = 1;
      if (clkstep_o > pc) begin
        n_chk++;
        if (!settled) begin
          n_fail++; mon_err++;
          $display("FAIL R4 clock raised before settle: act clk=%0d exp %0d", clkstep_o, pc);
        end
      end
      if (clkstep_o < pc) clk_dropped = 1;
      pv = vcode_o; pc = clkstep_o;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk); penable = 1; #1 d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 200; k++) begin
      apb_rd(8'h08, s);
      if (!s[16]) break;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge pclk);
    n_fail++;
    $display("FAIL watchdog: act=timeout exp=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1;
    // R1 reset state
    apb_rd(8'h08, rd);
    check(rd[7:0] == 7, "R1 cur", rd[7:0], 7);
    check(rd[15:8] == 7 && rd[16] == 0, "R1 tgt/busy", rd[16:8], 8'h07);
    check(vcode_o == 8'hB0 && clkstep_o == 7 && perf_lvl_o == 7, "R1 outputs", vcode_o, 8'hB0);
    apb_rd(8'h04, rd);
    check(rd == 7, "R1 ceiling", rd, 7);
    // R2 / R8 table default readback, entry 2
    apb_rd(8'h48, rd);
    check(rd == 32'h260, "R8 default entry 2", rd, 32'h260);

    // vector walk: R4, R5, R8
    for (int i = 0; i < VEC_N; i++) begin
      apb_wr(8'h00, {29'd0, V_REQ[i]});
      wait_idle();
      apb_rd(8'h08, rd);
      check(rd[7:0] == V_REQ[i], "R4/R5 cur level", rd[7:0], V_REQ[i]);
      check(vcode_o == V_VC[i] && clkstep_o == V_CK[i] && perf_lvl_o == V_REQ[i],
            "R8 vector outputs", {vcode_o, 1'b0, clkstep_o}, {V_VC[i], 1'b0, V_CK[i]});
    end

    // R9 equal request: no move
    apb_wr(8'h00, 32'd6);
    apb_rd(8'h08, rd);
    check(rd[16] == 0 && vcode_o == 8'hA0 && clkstep_o == 6, "R9 no move", rd[16], 0);

    // R6 / R7 request mid-move
    apb_wr(8'h00, 32'd1);
    apb_rd(8'h08, rd);
    check(rd[16] == 1 && rd[15:8] == 1, "R7 busy during move", rd[16:8], 9'h101);
    apb_wr(8'h00, 32'd4);
    wait_idle();
    apb_rd(8'h08, rd);
    check(rd[7:0] == 4 && rd[17] == 1, "R6 pending served", rd[17:0], 18'h20404);
    check(vcode_o == 8'h80 && clkstep_o == 4, "R6 outputs", vcode_o, 8'h80);

    // R3 ceiling clamp
    apb_wr(8'h04, 32'd2);
    apb_rd(8'h08, rd);
    check(rd[15:8] == 2, "R3 clamp by lowered ceiling", rd[15:8], 2);
    wait_idle();
    check(perf_lvl_o == 2 && vcode_o == 8'h60, "R3 moved to ceiling", perf_lvl_o, 2);
    apb_wr(8'h00, 32'd7);
    apb_rd(8'h08, rd);
    check(rd[15:8] == 2 && rd[16] == 0, "R3 request above ceiling", rd[16:8], 2);
    apb_rd(8'h00, rd);
    check(rd == 7, "R2 raw request readback", rd, 7);
    apb_wr(8'h04, 32'd7);
    wait_idle();
    check(perf_lvl_o == 7 && vcode_o == 8'hB0, "R3 ceiling restored", perf_lvl_o, 7);

    // R2 / R8 rewritten table entry
    apb_wr(8'h4C, 32'h655);
    apb_rd(8'h4C, rd);
    check(rd == 32'h655, "R2 table write readback", rd, 32'h655);
    apb_wr(8'h00, 32'd3);
    wait_idle();
    check(vcode_o == 8'h55 && clkstep_o == 6 && perf_lvl_o == 3, "R8 edited entry used",
          {vcode_o, clkstep_o}, {8'h55, 3'd6});
    apb_wr(8'h00, 32'd4);
    wait_idle();
    check(vcode_o == 8'h80 && clkstep_o == 4, "R4 up move with slower clock", vcode_o, 8'h80);

    check(mon_err == 0, "R4/R5 ordering monitor", mon_err, 0);
    summary();
    $finish;
  end
endmodule